// File: doc/BRIEF.md
# Gen3 Transmitter Equalization Phase Sequencer

This block walks a multi-lane PCI Express link through the transmitter equalization phases at 8 GT/s. It works from the downstream side. Each lane presents one decoded training set per `ts_valid` pulse. A set carries these fields: the two-bit equalization-control code, the preset-request flag, a 4-bit preset index, and 6-bit pre- and post-cursor values. It also has an error flag and a marker that tells an EQ TS2 apart from an ordinary set. The block has no back-pressure. A set is consumed in the cycle its valid bit is high, and there is no ready signal. The sender must therefore present each set for exactly one clock.

The sequencer captures the starting presets while the link still runs at a lower rate. It applies them when equalization begins. It advances one phase at a time. An advance needs a run of clean, consecutive sets that carry the code the current phase waits for, and every active lane must have such a run. In the tuning phase the block has no receive-quality metric, so it only reflects the coefficients it was given. A watchdog per phase aborts a stalled sequence.

Top module: `eq_phase_seq`

## Requirements
- R1: After reset, `phase` is 0 (idle), `tx_ec`, `adv_fs`, `adv_lf` and all `tx_*` outputs are 0, and `eq_done` and `eq_fail` are low.
- R2: While the block is idle, an error-free set with `ts_eqts2` high stores that lane's `ts_preset`. From the entry into phase 0 (`phase`=1) onward, the stored value appears on the lane's 4-bit field of `tx_preset`. EQ TS2 sets received after that entry do not change it.
- R3: The block leaves idle for phase 0 only when `eq_start` is high in a cycle in which `rate_8g` is high. A start pulse while `rate_8g` is low is ignored.
- R4: Phase 0 moves to phase 1 (`phase`=2) one cycle after every lane with `lane_active` high has seen GOOD_RUN consecutive error-free sets with EC=2'b01. A set with `ts_err` high restarts that lane's run. A set with any other EC value also restarts it. Inactive lanes are not considered.
- R5: `tx_ec` shows the phase's own code: 2'b01 in phase 1, 2'b10 in phase 2, 2'b11 in phase 3, and 2'b00 otherwise. `adv_fs` and `adv_lf` equal the FS and LF parameters (defaults 40 and 13) only in phase 1, and are 0 otherwise.
- R6: Phase 1 moves to phase 2 (`phase`=3) after GOOD_RUN consecutive sets with EC=2'b10 on all active lanes. Each lane then drives the pre- and post-cursor of its last error-free set in phase 1. `tx_main` equals FS minus pre minus post, so the three cursors sum to FS whenever pre plus post does not exceed FS.
- R7: In phase 2, requests do not change `tx_preset`, `tx_pre`, `tx_main` or `tx_post`. The lane's `echo_preset` bit takes the preset-request flag of the last error-free set. A value of 1 means a preset is echoed, and 0 means coefficients are echoed.
- R8: Phase 2 moves to phase 3 (`phase`=4) after GOOD_RUN consecutive sets with EC=2'b11 on all active lanes. `eq_done` is high in phase 3. The block returns to idle one cycle after `rate_8g` falls.
- R9: If the block spends TIMEOUT cycles in phase 0, 1 or 2 without advancing, it returns to idle and sets `eq_fail`. `eq_fail` stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_8g | input | 1 | Link is running at 8 GT/s |
| eq_start | input | 1 | Speed change completed; begin equalization |
| lane_active | input | LANES | Lanes taking part in the advance decision |
| ts_valid | input | LANES | One decoded training set present on the lane |
| ts_err | input | LANES | Decode error on the lane |
| ts_eqts2 | input | LANES | The set is an EQ TS2 carrying a starting preset |
| ts_use_preset | input | LANES | Received preset-request flag |
| ts_ec | input | 2*LANES | Received equalization-control code per lane |
| ts_preset | input | 4*LANES | Received preset index per lane |
| ts_pre | input | 6*LANES | Received pre-cursor per lane |
| ts_post | input | 6*LANES | Received post-cursor per lane |
| phase | output | 3 | 0 idle, 1 phase 0, 2 phase 1, 3 phase 2, 4 phase 3 |
| tx_ec | output | 2 | EC code for outgoing sets |
| adv_fs | output | 6 | Advertised full swing (phase 1 only) |
| adv_lf | output | 6 | Advertised low-frequency bound (phase 1 only) |
| tx_preset | output | 4*LANES | Transmitter preset per lane |
| tx_pre | output | 6*LANES | Transmitter pre-cursor per lane |
| tx_main | output | 6*LANES | Transmitter main cursor per lane |
| tx_post | output | 6*LANES | Transmitter post-cursor per lane |
| echo_preset | output | LANES | Last phase-2 request was a preset request |
| eq_done | output | 1 | Equalization reached phase 3 |
| eq_fail | output | 1 | Equalization aborted by timeout |

## Verification
The advance rule is tested in three ways. Clean runs of the right code on all lanes show that the count threshold is exact. A run broken by an error on one lane shows that each lane keeps its own count. A lane that is left inactive and silent shows that the decision masks it. The phase-1 cursor values are random, and two different batches are sent. Only the last batch must appear, and each main cursor is checked against FS minus the side cursors. In phase 2, both preset and coefficient requests carry fresh random values, which shows they are reflected and not applied. A silent phase 0 held to the cycle before and after the limit pins down the timeout.

// File: rtl/eqs_pkg.sv
package eqs_pkg;

  localparam int PRESET_W = 4;
  localparam int COEF_W   = 6;
  localparam int EC_W     = 2;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_0    = 3'd1,
    PH_1    = 3'd2,
    PH_2    = 3'd3,
    PH_3    = 3'd4
  } eq_phase_e;

  // EC code a lane must receive before the current phase may advance
  function automatic logic [EC_W-1:0] ec_awaited(eq_phase_e p);
    case (p)
      PH_0:    return 2'b01;
      PH_1:    return 2'b10;
      PH_2:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // EC code this side places in outgoing sets
  function automatic logic [EC_W-1:0] ec_emitted(eq_phase_e p);
    case (p)
      PH_1:    return 2'b01;
      PH_2:    return 2'b10;
      PH_3:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic in_training(eq_phase_e p);
    return (p == PH_0) || (p == PH_1) || (p == PH_2);
  endfunction

endpackage

// File: rtl/eqs_lane.sv
module eqs_lane
  import eqs_pkg::*;
#(
  parameter int GOOD_RUN = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  eq_phase_e           phase,
  input  logic                clr,
  input  logic                ts_valid,
  input  logic                ts_err,
  input  logic                ts_eqts2,
  input  logic [EC_W-1:0]     ts_ec,
  input  logic                ts_use_preset,
  input  logic [PRESET_W-1:0] ts_preset,
  input  logic [COEF_W-1:0]   ts_pre,
  input  logic [COEF_W-1:0]   ts_post,
  output logic                qual,
  output logic [PRESET_W-1:0] start_preset,
  output logic [COEF_W-1:0]   cur_pre,
  output logic [COEF_W-1:0]   cur_post,
  output logic                echo_preset
);

  localparam int CNT_W = $clog2(GOOD_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_TOP = CNT_W'(GOOD_RUN);

  logic [CNT_W-1:0] run_cnt;
  logic             good;

  assign good = ts_valid && !ts_err;

  // consecutive-good counter, restarted by errors, wrong codes and phase changes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (clr || ts_err) begin
      run_cnt <= '0;
    end else if (ts_valid) begin
      if (in_training(phase) && ts_ec == ec_awaited(phase))
        run_cnt <= (run_cnt == RUN_TOP) ? run_cnt : run_cnt + 1'b1;
      else
        run_cnt <= '0;
    end
  end

  assign qual = (run_cnt == RUN_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_preset <= '0;
    end else if (phase == PH_IDLE && good && ts_eqts2) begin
      start_preset <= ts_preset;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_pre  <= '0;
      cur_post <= '0;
    end else if (phase == PH_1 && good) begin
      cur_pre  <= ts_pre;
      cur_post <= ts_post;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_preset <= 1'b0;
    end else if (phase == PH_IDLE) begin
      echo_preset <= 1'b0;
    end else if (phase == PH_2 && good) begin
      echo_preset <= ts_use_preset;
    end
  end

  // R4: a decode error leaves the run empty on the next cycle
  assert_err_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ts_err |=> (run_cnt == '0));

  // R2: once equalization is running the starting preset is frozen
  assert_preset_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(start_preset));

  // R7: phase 2 only reflects; the side cursors never move there
  assert_reflect_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_2 && $past(phase) == PH_2) |-> ($stable(cur_pre) && $stable(cur_post)));

endmodule

// File: rtl/eqs_ctrl.sv
module eqs_ctrl
  import eqs_pkg::*;
#(
  parameter int TIMEOUT = 4096
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      rate_8g,
  input  logic      all_ok,
  output eq_phase_e phase,
  output logic      advance,
  output logic      fail
);

  localparam int TMO_W = $clog2(TIMEOUT + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);

  eq_phase_e        state, nxt;
  logic [TMO_W-1:0] tmo;
  logic             expire;

  always_comb begin
    nxt     = state;
    advance = 1'b0;
    expire  = 1'b0;
    case (state)
      PH_IDLE: if (start && rate_8g) begin nxt = PH_0; advance = 1'b1; end
      PH_0: begin
        if (all_ok) begin nxt = PH_1; advance = 1'b1; end
        else if (tmo == TMO_LAST) begin nxt = PH_IDLE; expire = 1'b1; end
      end
      PH_1: begin
        if (all_ok) begin nxt = PH_2; advance = 1'b1; end
        else if (tmo == TMO_LAST) begin nxt = PH_IDLE; expire = 1'b1; end
      end
      PH_2: begin
        if (all_ok) begin nxt = PH_3; advance = 1'b1; end
        else if (tmo == TMO_LAST) begin nxt = PH_IDLE; expire = 1'b1; end
      end
      PH_3: if (!rate_8g) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      tmo   <= '0;
      fail  <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state || !in_training(state)) tmo <= '0;
      else                                      tmo <= tmo + 1'b1;
      if (state == PH_IDLE && start && rate_8g) fail <= 1'b0;
      else if (expire)                           fail <= 1'b1;
    end
  end

  assign phase = state;

  // R4: phase 1 is only reached from phase 0
  assert_p1_from_p0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_1 && $past(state) != PH_1) |-> ($past(state) == PH_0));

  // R8: phase 3 is only reached from phase 2
  assert_p3_from_p2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_3 && $past(state) != PH_3) |-> ($past(state) == PH_2));

  // R9: a failure always lands in idle
  assert_fail_in_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (state == PH_IDLE));

  // R3: leaving idle needs the 8 GT/s rate
  assert_entry_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE) |=> (state == PH_IDLE || $past(rate_8g)));

endmodule

// File: rtl/eq_phase_seq.sv
module eq_phase_seq
  import eqs_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int GOOD_RUN = 8,
  parameter int TIMEOUT  = 4096,
  parameter int FS       = 40,
  parameter int LF       = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rate_8g,
  input  logic                      eq_start,
  input  logic [LANES-1:0]          lane_active,
  input  logic [LANES-1:0]          ts_valid,
  input  logic [LANES-1:0]          ts_err,
  input  logic [LANES-1:0]          ts_eqts2,
  input  logic [LANES-1:0]          ts_use_preset,
  input  logic [EC_W*LANES-1:0]     ts_ec,
  input  logic [PRESET_W*LANES-1:0] ts_preset,
  input  logic [COEF_W*LANES-1:0]   ts_pre,
  input  logic [COEF_W*LANES-1:0]   ts_post,
  output logic [2:0]                phase,
  output logic [EC_W-1:0]           tx_ec,
  output logic [COEF_W-1:0]         adv_fs,
  output logic [COEF_W-1:0]         adv_lf,
  output logic [PRESET_W*LANES-1:0] tx_preset,
  output logic [COEF_W*LANES-1:0]   tx_pre,
  output logic [COEF_W*LANES-1:0]   tx_main,
  output logic [COEF_W*LANES-1:0]   tx_post,
  output logic [LANES-1:0]          echo_preset,
  output logic                      eq_done,
  output logic                      eq_fail
);

  localparam logic [COEF_W-1:0] FS_V = COEF_W'(FS);
  localparam logic [COEF_W-1:0] LF_V = COEF_W'(LF);

  eq_phase_e        ph;
  logic             advance;
  logic             all_ok;
  logic [LANES-1:0] qual;

  eqs_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eq_start),
    .rate_8g (rate_8g),
    .all_ok  (all_ok),
    .phase   (ph),
    .advance (advance),
    .fail    (eq_fail)
  );

  assign all_ok = (&(qual | ~lane_active)) && (|lane_active);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [PRESET_W-1:0] sp;
    logic [COEF_W-1:0]   cp, cq;
    logic                coefs_on;

    eqs_lane #(.GOOD_RUN(GOOD_RUN)) u_lane (
      .clk           (clk),
      .rst_n         (rst_n),
      .phase         (ph),
      .clr           (advance),
      .ts_valid      (ts_valid[i]),
      .ts_err        (ts_err[i]),
      .ts_eqts2      (ts_eqts2[i]),
      .ts_ec         (ts_ec[EC_W*i +: EC_W]),
      .ts_use_preset (ts_use_preset[i]),
      .ts_preset     (ts_preset[PRESET_W*i +: PRESET_W]),
      .ts_pre        (ts_pre[COEF_W*i +: COEF_W]),
      .ts_post       (ts_post[COEF_W*i +: COEF_W]),
      .qual          (qual[i]),
      .start_preset  (sp),
      .cur_pre       (cp),
      .cur_post      (cq),
      .echo_preset   (echo_preset[i])
    );

    assign coefs_on = (ph == PH_2) || (ph == PH_3);
    assign tx_preset[PRESET_W*i +: PRESET_W] = (ph != PH_IDLE) ? sp : '0;
    assign tx_pre [COEF_W*i +: COEF_W] = coefs_on ? cp : '0;
    assign tx_post[COEF_W*i +: COEF_W] = coefs_on ? cq : '0;
    assign tx_main[COEF_W*i +: COEF_W] = coefs_on ? (FS_V - cp - cq) : '0;
  end

  assign phase   = ph;
  assign tx_ec   = ec_emitted(ph);
  assign adv_fs  = (ph == PH_1) ? FS_V : '0;
  assign adv_lf  = (ph == PH_1) ? LF_V : '0;
  assign eq_done = (ph == PH_3);

endmodule

// File: tb/eq_phase_seq_test.sv
module eq_phase_seq_test;

  localparam int L   = 4;
  localparam int RUN = 3;
  localparam int TMO = 64;
  localparam int FSP = 40;
  localparam int LFP = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_8g = 1'b0;
  logic eq_start = 1'b0;
  logic [L-1:0] lane_active = '1;
  logic [L-1:0] ts_valid = '0, ts_err = '0, ts_eqts2 = '0, ts_use_preset = '0;
  logic [2*L-1:0] ts_ec = '0;
  logic [4*L-1:0] ts_preset = '0;
  logic [6*L-1:0] ts_pre = '0, ts_post = '0;
  logic [2:0] phase;
  logic [1:0] tx_ec;
  logic [5:0] adv_fs, adv_lf;
  logic [4*L-1:0] tx_preset;
  logic [6*L-1:0] tx_pre, tx_main, tx_post;
  logic [L-1:0] echo_preset;
  logic eq_done, eq_fail;

  int checks = 0;
  int errors = 0;

  logic [3:0] b_preset [L];
  logic [5:0] b_pre [L], b_post [L];
  logic [3:0] e_preset [L];
  logic [5:0] s_pre [L], s_post [L];

  always #5 clk = ~clk;

  eq_phase_seq #(.LANES(L), .GOOD_RUN(RUN), .TIMEOUT(TMO), .FS(FSP), .LF(LFP)) uut (
    .clk(clk), .rst_n(rst_n), .rate_8g(rate_8g), .eq_start(eq_start),
    .lane_active(lane_active), .ts_valid(ts_valid), .ts_err(ts_err),
    .ts_eqts2(ts_eqts2), .ts_use_preset(ts_use_preset), .ts_ec(ts_ec),
    .ts_preset(ts_preset), .ts_pre(ts_pre), .ts_post(ts_post),
    .phase(phase), .tx_ec(tx_ec), .adv_fs(adv_fs), .adv_lf(adv_lf),
    .tx_preset(tx_preset), .tx_pre(tx_pre), .tx_main(tx_main), .tx_post(tx_post),
    .echo_preset(echo_preset), .eq_done(eq_done), .eq_fail(eq_fail)
  );

  function automatic logic [5:0] exp_main(logic [5:0] p, logic [5:0] q);
    return 6'(FSP) - p - q;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic fill_rand();
    for (int i = 0; i < L; i++) begin
      b_preset[i] = 4'($urandom_range(0, 10));
      b_pre[i]    = 6'($urandom_range(0, 10));
      b_post[i]   = 6'($urandom_range(0, 15));
    end
  endtask

  task automatic keep_coefs();
    for (int i = 0; i < L; i++) begin s_pre[i] = b_pre[i]; s_post[i] = b_post[i]; end
  endtask

  task automatic keep_presets();
    for (int i = 0; i < L; i++) e_preset[i] = b_preset[i];
  endtask

  task automatic send(input logic [L-1:0] vm, input logic [L-1:0] em,
                      input logic [1:0] ec, input logic eq2, input logic up);
    @(negedge clk);
    ts_valid = vm; ts_err = em; ts_eqts2 = {L{eq2}}; ts_use_preset = {L{up}};
    for (int i = 0; i < L; i++) begin
      ts_ec[2*i +: 2]     = ec;
      ts_preset[4*i +: 4] = b_preset[i];
      ts_pre[6*i +: 6]    = b_pre[i];
      ts_post[6*i +: 6]   = b_post[i];
    end
    @(negedge clk);
    ts_valid = '0; ts_err = '0;
  endtask

  task automatic pulse_start();
    @(negedge clk); eq_start = 1'b1;
    @(negedge clk); eq_start = 1'b0;
  endtask

  task automatic chk_presets(input string req);
    for (int i = 0; i < L; i++) chk(req, 32'(tx_preset[4*i +: 4]), 32'(e_preset[i]));
  endtask

  task automatic chk_coefs(input string req);
    for (int i = 0; i < L; i++) begin
      chk(req, 32'(tx_pre[6*i +: 6]),  32'(s_pre[i]));
      chk(req, 32'(tx_post[6*i +: 6]), 32'(s_post[i]));
      chk(req, 32'(tx_main[6*i +: 6]), 32'(exp_main(s_pre[i], s_post[i])));
    end
  endtask

  task automatic run_round();
    rate_8g = 1'b0;
    fill_rand();
    send('1, '0, 2'b00, 1'b1, 1'b0);
    keep_presets();
    rate_8g = 1'b1;
    pulse_start();
    chk("R3 enter phase 0", 32'(phase), 32'd1);
    chk_presets("R2 preset applied");
    repeat (RUN) send('1, '0, 2'b01, 1'b0, 1'b0);
    settle();
    chk("R4 to phase 1", 32'(phase), 32'd2);
    chk("R5 fs", 32'(adv_fs), 32'(FSP));
    fill_rand();
    repeat (RUN) send('1, '0, 2'b10, 1'b0, 1'b0);
    keep_coefs();
    settle();
    chk("R6 to phase 2", 32'(phase), 32'd3);
    chk_coefs("R6 coefs");
    repeat (RUN) send('1, '0, 2'b11, 1'b0, 1'b0);
    settle();
    chk("R8 to phase 3", 32'(phase), 32'd4);
    chk("R8 done", 32'(eq_done), 32'd1);
    rate_8g = 1'b0;
    settle();
    chk("R8 back to idle", 32'(phase), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 phase", 32'(phase), 32'd0);
    chk("R1 tx_ec", 32'(tx_ec), 32'd0);
    chk("R1 adv", 32'({adv_fs, adv_lf}), 32'd0);
    chk("R1 preset", 32'(tx_preset), 32'd0);
    chk("R1 flags", 32'({eq_done, eq_fail}), 32'd0);
    rst_n = 1'b1;
    settle();
    chk("R1 after release", 32'(phase), 32'd0);

    // R2 capture at low rate; R3 start without the 8 GT/s rate is ignored
    fill_rand();
    send('1, '0, 2'b00, 1'b1, 1'b0);
    keep_presets();
    pulse_start();
    settle();
    chk("R3 start ignored at low rate", 32'(phase), 32'd0);
    rate_8g = 1'b1;
    pulse_start();
    chk("R3 enter phase 0", 32'(phase), 32'd1);
    chk("R5 tx_ec phase 0", 32'(tx_ec), 32'd0);
    chk_presets("R2 preset applied");
    fill_rand();
    send('1, '0, 2'b00, 1'b1, 1'b0);
    settle();
    chk_presets("R2 late EQ TS2 ignored");

    // R4 lane 3 inactive and silent; an error on lane 2 restarts its run
    lane_active = 4'b0111;
    repeat (2) send(4'b0111, '0, 2'b01, 1'b0, 1'b0);
    send(4'b0111, 4'b0100, 2'b01, 1'b0, 1'b0);
    repeat (2) send(4'b0111, '0, 2'b01, 1'b0, 1'b0);
    settle();
    chk("R4 error restarts run", 32'(phase), 32'd1);
    send(4'b0111, '0, 2'b00, 1'b0, 1'b0);
    repeat (2) send(4'b0111, '0, 2'b01, 1'b0, 1'b0);
    settle();
    chk("R4 wrong EC restarts run", 32'(phase), 32'd1);
    send(4'b0111, '0, 2'b01, 1'b0, 1'b0);
    settle();
    chk("R4 advance to phase 1", 32'(phase), 32'd2);
    chk("R5 fs", 32'(adv_fs), 32'(FSP));
    chk("R5 lf", 32'(adv_lf), 32'(LFP));
    chk("R5 tx_ec phase 1", 32'(tx_ec), 32'd1);

    // R6 only the last set of phase 1 is latched
    fill_rand();
    repeat (2) send('1, '0, 2'b10, 1'b0, 1'b0);
    fill_rand();
    send('1, '0, 2'b10, 1'b0, 1'b0);
    keep_coefs();
    settle();
    chk("R6 advance to phase 2", 32'(phase), 32'd3);
    chk("R5 tx_ec phase 2", 32'(tx_ec), 32'd2);
    chk("R5 adv off outside phase 1", 32'({adv_fs, adv_lf}), 32'd0);
    chk_coefs("R6 latched coefs");

    // R7 requests are reflected, not applied
    fill_rand();
    send('1, '0, 2'b10, 1'b0, 1'b1);
    settle();
    chk_coefs("R7 preset request ignored");
    chk_presets("R7 preset unchanged");
    chk("R7 echo preset", 32'(echo_preset), 32'hF);
    fill_rand();
    send('1, '0, 2'b10, 1'b0, 1'b0);
    settle();
    chk_coefs("R7 coef request ignored");
    chk("R7 echo coefs", 32'(echo_preset), 32'h0);

    // R8
    repeat (RUN) send('1, '0, 2'b11, 1'b0, 1'b0);
    settle();
    chk("R8 phase 3", 32'(phase), 32'd4);
    chk("R8 done", 32'(eq_done), 32'd1);
    chk("R5 tx_ec phase 3", 32'(tx_ec), 32'd3);
    rate_8g = 1'b0;
    settle();
    chk("R8 idle after rate drop", 32'(phase), 32'd0);
    chk("R8 done clears", 32'(eq_done), 32'd0);
    lane_active = '1;

    for (int r = 0; r < 5; r++) run_round();

    // R9 timeout in a silent phase 0
    rate_8g = 1'b1;
    pulse_start();
    repeat (TMO - 2) @(negedge clk);
    chk("R9 still phase 0 before limit", 32'(phase), 32'd1);
    chk("R9 no fail before limit", 32'(eq_fail), 32'd0);
    repeat (2) @(negedge clk);
    chk("R9 idle at limit", 32'(phase), 32'd0);
    chk("R9 fail set", 32'(eq_fail), 32'd1);
    repeat (4) @(negedge clk);
    chk("R9 fail held", 32'(eq_fail), 32'd1);
    pulse_start();
    chk("R9 fail cleared by start", 32'(eq_fail), 32'd0);
    chk_presets("R2 preset kept across sessions");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule